// File: doc/BRIEF.md
# Oversampling Resolution Averager

This block sits between a 12-bit sampling core and the result storage. A small mode code picks one of three output formats. Native mode passes each raw sample through unchanged. Narrow mode keeps the top ten bits of each sample. Enhanced mode returns between 13 and 16 bits. Whatever the format, the result is zero-extended into a 16-bit word, so that a 16-bit transfer can carry it directly.

In enhanced mode the block adds up a run of consecutive raw samples taken on one channel with one mode code. The run length is a power of four: 4, 16, 64 or 256 samples. When the run is complete, the sum is shifted right to the selected width and one result is posted. The result rate is therefore the sample rate divided by the run length. If a sample arrives with a different channel or mode code, the partial sum is dropped and a new run starts with that sample. Samples do not need to arrive on consecutive cycles.

Top module: `ovs_averager`

## Requirements
- R1: With mode code 0, each accepted sample (`smp_vld_i` high) produces `res_vld_o` high on the next cycle, with `res_o` equal to the 12-bit sample zero-extended to 16 bits.
- R2: With mode code 1, the result is the sample shifted right by 2, placed in bits 9:0, and bits 15:10 are zero. It appears on the next cycle.
- R3: With mode codes 2, 3, 4 and 5, exactly one result is produced for every 4, 16, 64 and 256 samples respectively that share a channel and mode code. The result appears on the cycle after the last sample of the run.
- R4: An enhanced result for code c is the sum of the run shifted right by n = c-1. It is 12+n bits wide, and all bits above that width are zero.
- R5: Mode codes 6 and 7 behave exactly like code 5: runs of 256 samples and 16-bit results.
- R6: A sample whose channel or mode code differs from the run in progress discards the partial sum, and that sample becomes the first sample of a new run. A native-mode or narrow-mode sample also discards any partial sum.
- R7: `res_vld_o` is high for exactly one cycle per result, and never in a cycle that does not follow an accepted sample.
- R8: `res_ch_o` equals the channel of the sample or run that produced the result.
- R9: Reset (`rst_ni` low) forces `res_vld_o` low and discards any partial sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_vld_i | input | 1 | Raw sample valid |
| smp_i | input | 12 | Raw sample value |
| smp_ch_i | input | 4 | Channel number of the sample |
| mode_i | input | 3 | Mode code (0 native, 1 narrow, 2..7 enhanced) |
| res_vld_o | output | 1 | Single-cycle result strobe |
| res_o | output | 16 | Zero-extended result word |
| res_ch_o | output | 4 | Channel of the result |

## Verification
The assertions assume that `smp_i`, `smp_ch_i` and `mode_i` are meaningful only while `smp_vld_i` is high, and that `mode_i` always holds a defined 3-bit code. The stimulus drives these inputs once per cycle, between clock edges. It holds one channel and one mode code for a burst, sometimes ending the burst before a run is complete so that the discard path is exercised, and it leaves random idle gaps between samples. Directed cases cover full-scale runs, the clamped codes and a reset in the middle of a run.

// File: rtl/ovs_pkg.sv
package ovs_pkg;

    localparam int unsigned MODE_W = 3;

    typedef enum logic [1:0] {
        FMT_NATIVE = 2'd0,
        FMT_NARROW = 2'd1,
        FMT_ENH    = 2'd2
    } fmt_e;

    // extra result bits requested by a mode code, clamped to the supported maximum
    function automatic int unsigned ext_of(input logic [MODE_W-1:0] code, input int unsigned max_n);
        int unsigned e;
        if (code < MODE_W'(2)) e = 0;
        else                   e = 32'(code) - 1;
        if (e > max_n) e = max_n;
        return e;
    endfunction

    function automatic fmt_e fmt_of(input logic [MODE_W-1:0] code);
        if (code == MODE_W'(0))      return FMT_NATIVE;
        else if (code == MODE_W'(1)) return FMT_NARROW;
        else                         return FMT_ENH;
    endfunction

endpackage

// File: rtl/ovs_mode_decode.sv
module ovs_mode_decode
    import ovs_pkg::*;
#(
    parameter int unsigned MAX_N = 4,
    localparam int unsigned EXT_W = $clog2(MAX_N + 1)
) (
    input  logic [MODE_W-1:0] mode_i,
    output fmt_e              fmt_o,
    output logic [EXT_W-1:0]  ext_o
);

    always_comb begin
        fmt_o = fmt_of(mode_i);
        ext_o = EXT_W'(ext_of(mode_i, MAX_N));
    end

endmodule

// File: rtl/ovs_accum.sv
module ovs_accum
    import ovs_pkg::*;
#(
    parameter int unsigned RAW_W = 12,
    parameter int unsigned CH_W  = 4,
    parameter int unsigned MAX_N = 4,
    localparam int unsigned EXT_W = $clog2(MAX_N + 1),
    localparam int unsigned ACC_W = RAW_W + 2 * MAX_N,
    localparam int unsigned CNT_W = 2 * MAX_N + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              smp_vld_i,
    input  logic [RAW_W-1:0]  smp_i,
    input  logic [CH_W-1:0]   ch_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              enh_i,
    input  logic [EXT_W-1:0]  ext_i,
    output logic              done_o,
    output logic [ACC_W-1:0]  sum_o
);

    typedef struct packed {
        logic              active;
        logic [ACC_W-1:0]  acc;
        logic [CNT_W-1:0]  cnt;
        logic [MODE_W-1:0] mode;
        logic [CH_W-1:0]   ch;
    } acc_t;

    acc_t acc_d, acc_q;
    logic             restart;
    logic [CNT_W-1:0] target, cnt_next, q_limit;

    always_comb begin
        acc_d    = acc_q;
        done_o   = 1'b0;
        restart  = !acc_q.active || (mode_i != acc_q.mode) || (ch_i != acc_q.ch);
        target   = CNT_W'(1) << {ext_i, 1'b0};
        sum_o    = (restart ? '0 : acc_q.acc) + ACC_W'(smp_i);
        cnt_next = (restart ? '0 : acc_q.cnt) + CNT_W'(1);
        q_limit  = CNT_W'(1) << (2 * ext_of(acc_q.mode, MAX_N));
        if (smp_vld_i) begin
            if (!enh_i || cnt_next == target) begin
                done_o        = enh_i;
                acc_d.active  = 1'b0;
                acc_d.acc     = '0;
                acc_d.cnt     = '0;
            end else begin
                acc_d.active  = 1'b1;
                acc_d.acc     = sum_o;
                acc_d.cnt     = cnt_next;
                acc_d.mode    = mode_i;
                acc_d.ch      = ch_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) acc_q <= '0;
        else         acc_q <= acc_d;
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_q.active |-> (acc_q.cnt != '0) && (acc_q.cnt < q_limit));

    // R6
    restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (smp_vld_i && enh_i && acc_q.active && (ch_i != acc_q.ch)) |=> (acc_q.active && acc_q.cnt == CNT_W'(1)));

    // R6
    passthru_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (smp_vld_i && !enh_i) |=> !acc_q.active);

endmodule

// File: rtl/ovs_format.sv
module ovs_format
    import ovs_pkg::*;
#(
    parameter int unsigned RAW_W = 12,
    parameter int unsigned MAX_N = 4,
    parameter int unsigned DROP  = 2,
    localparam int unsigned EXT_W = $clog2(MAX_N + 1),
    localparam int unsigned ACC_W = RAW_W + 2 * MAX_N,
    localparam int unsigned OUT_W = RAW_W + MAX_N,
    localparam int unsigned WID_W = $clog2(OUT_W + 1)
) (
    input  fmt_e              fmt_i,
    input  logic [EXT_W-1:0]  ext_i,
    input  logic [RAW_W-1:0]  raw_i,
    input  logic [ACC_W-1:0]  sum_i,
    output logic [OUT_W-1:0]  data_o,
    output logic [WID_W-1:0]  width_o
);

    always_comb begin
        unique case (fmt_i)
            FMT_NATIVE: begin
                data_o  = OUT_W'(raw_i);
                width_o = WID_W'(RAW_W);
            end
            FMT_NARROW: begin
                data_o  = OUT_W'(raw_i >> DROP);
                width_o = WID_W'(RAW_W - DROP);
            end
            default: begin
                data_o  = OUT_W'(sum_i >> ext_i);
                width_o = WID_W'(RAW_W) + WID_W'(ext_i);
            end
        endcase
    end

endmodule

// File: rtl/ovs_averager.sv
module ovs_averager
    import ovs_pkg::*;
#(
    parameter int unsigned RAW_W = 12,
    parameter int unsigned CH_W  = 4,
    parameter int unsigned MAX_N = 4,
    parameter int unsigned DROP  = 2,
    localparam int unsigned EXT_W = $clog2(MAX_N + 1),
    localparam int unsigned ACC_W = RAW_W + 2 * MAX_N,
    localparam int unsigned OUT_W = RAW_W + MAX_N,
    localparam int unsigned WID_W = $clog2(OUT_W + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              smp_vld_i,
    input  logic [RAW_W-1:0]  smp_i,
    input  logic [CH_W-1:0]   smp_ch_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              res_vld_o,
    output logic [OUT_W-1:0]  res_o,
    output logic [CH_W-1:0]   res_ch_o
);

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] data;
        logic [CH_W-1:0]  ch;
        logic [WID_W-1:0] wid;
    } out_t;

    out_t             out_d, out_q;
    fmt_e             fmt;
    logic [EXT_W-1:0] ext;
    logic             done;
    logic [ACC_W-1:0] sum;
    logic [OUT_W-1:0] fmt_data;
    logic [WID_W-1:0] fmt_wid;

    ovs_mode_decode #(.MAX_N(MAX_N)) i_decode (
        .mode_i (mode_i),
        .fmt_o  (fmt),
        .ext_o  (ext)
    );

    ovs_accum #(.RAW_W(RAW_W), .CH_W(CH_W), .MAX_N(MAX_N)) i_accum (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .smp_vld_i (smp_vld_i),
        .smp_i     (smp_i),
        .ch_i      (smp_ch_i),
        .mode_i    (mode_i),
        .enh_i     (fmt == FMT_ENH),
        .ext_i     (ext),
        .done_o    (done),
        .sum_o     (sum)
    );

    ovs_format #(.RAW_W(RAW_W), .MAX_N(MAX_N), .DROP(DROP)) i_format (
        .fmt_i   (fmt),
        .ext_i   (ext),
        .raw_i   (smp_i),
        .sum_i   (sum),
        .data_o  (fmt_data),
        .width_o (fmt_wid)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = smp_vld_i && ((fmt != FMT_ENH) || done);
        if (out_d.vld) begin
            out_d.data = fmt_data;
            out_d.ch   = smp_ch_i;
            out_d.wid  = fmt_wid;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign res_vld_o = out_q.vld;
    assign res_o     = out_q.data;
    assign res_ch_o  = out_q.ch;

    // R7
    lone_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !smp_vld_i |=> !res_vld_o);

    // R2 R4
    width_fit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_vld_o |-> ((res_o >> out_q.wid) == '0));

    // R8
    ch_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (smp_vld_i && fmt != FMT_ENH) |=> (res_vld_o && res_ch_o == $past(smp_ch_i)));

endmodule

// File: tb/test_ovs_averager.sv
module test_ovs_averager;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        smp_vld_i = 1'b0;
    logic [11:0] smp_i = '0;
    logic [3:0]  smp_ch_i = '0;
    logic [2:0]  mode_i = '0;
    logic        res_vld_o;
    logic [15:0] res_o;
    logic [3:0]  res_ch_o;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;

    // reference model state
    bit m_active = 0;
    int m_acc = 0;
    int m_cnt = 0;
    int m_mode = 0;
    int m_ch = 0;

    always #5 clk_i = ~clk_i;

    ovs_averager i_ovs_averager (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .smp_vld_i (smp_vld_i),
        .smp_i     (smp_i),
        .smp_ch_i  (smp_ch_i),
        .mode_i    (mode_i),
        .res_vld_o (res_vld_o),
        .res_o     (res_o),
        .res_ch_o  (res_ch_o)
    );

    function automatic int ext_bits(input int mode);
        if (mode < 2) return 0;
        if (mode > 5) return 4;
        return mode - 1;
    endfunction

    function automatic string mode_tag(input int mode);
        if (mode == 0) return "R1";
        if (mode == 1) return "R2";
        if (mode > 5)  return "R5";
        return "R4";
    endfunction

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    task automatic check_out(input string tag, input bit ev, input int ed, input int ec);
        n_checks++;
        if (res_vld_o !== ev) begin
            n_errors++;
            $display("FAIL %s valid: got %0b expected %0b", tag, res_vld_o, ev);
        end
        if (ev && res_vld_o === 1'b1) begin
            n_checks++;
            if (res_o !== 16'(ed)) begin
                n_errors++;
                $display("FAIL %s data: got %0d expected %0d", tag, res_o, ed);
            end
            n_checks++;
            if (res_ch_o !== 4'(ec)) begin
                n_errors++;
                $display("FAIL R8 channel: got %0d expected %0d", res_ch_o, ec);
            end
        end
    endtask

    // one sample per cycle; result checked just after the capturing edge
    task automatic send(input int raw, input int ch, input int mode, input string tag);
        bit ev;
        int ed;
        int n;
        @(negedge clk_i);
        smp_vld_i = 1'b1;
        smp_i     = 12'(raw);
        smp_ch_i  = 4'(ch);
        mode_i    = 3'(mode);
        ev = 0;
        ed = 0;
        if (mode == 0) begin
            ev = 1; ed = raw; m_active = 0;
        end else if (mode == 1) begin
            ev = 1; ed = raw >> 2; m_active = 0;
        end else begin
            n = ext_bits(mode);
            if (!m_active || mode != m_mode || ch != m_ch) begin
                m_acc = 0; m_cnt = 0;
            end
            m_acc += raw; m_cnt++;
            m_mode = mode; m_ch = ch; m_active = 1;
            if (m_cnt == (1 << (2 * n))) begin
                ev = 1; ed = m_acc >> n; m_active = 0;
            end
        end
        @(posedge clk_i);
        #1;
        check_out(tag, ev, ed, ch);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk_i);
            smp_vld_i = 1'b0;
            smp_i = 12'($urandom);
            @(posedge clk_i);
            #1;
            check_out("R7", 0, 0, 0);
        end
    endtask

    task automatic do_reset();
        @(negedge clk_i);
        smp_vld_i = 1'b0;
        rst_ni = 1'b0;
        m_active = 0;
        @(negedge clk_i);
        #1;
        check_out("R9", 0, 0, 0);
        rst_ni = 1'b1;
    endtask

    initial begin
        forever begin
            @(posedge clk_i);
            cycles++;
            if (cycles > 150000) begin
                n_errors++;
                $display("FAIL watchdog: got %0d cycles expected below 150000", cycles);
                report();
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk_i);
        n_checks++;
        if (res_vld_o !== 1'b0) begin
            n_errors++;
            $display("FAIL R9 reset valid: got %0b expected 0", res_vld_o);
        end
        rst_ni = 1'b1;
        idle(2);

        // R1 native pass-through, full scale and zero
        send(4095, 3, 0, "R1");
        send(0, 3, 0, "R1");
        send(2730, 9, 0, "R1");
        // R2 narrow mode drops two bits
        send(4095, 1, 1, "R2");
        send(3, 1, 1, "R2");
        idle(1);

        // R3 R4 full-scale 256-sample run for 16 bits
        for (int i = 0; i < 256; i++) send(4095, 5, 5, "R3");
        idle(1);
        // R5 clamped code 7 acts as 16-bit mode
        for (int i = 0; i < 256; i++) send(4095, 6, 7, "R5");
        // R3 4-sample runs back to back
        for (int i = 0; i < 8; i++) send(100 + i, 2, 2, "R3");
        // R6 channel change mid-run restarts
        send(1000, 2, 2, "R6");
        send(1000, 2, 2, "R6");
        for (int i = 0; i < 4; i++) send(4000, 4, 2, "R6");
        // R6 mode change mid-run restarts
        for (int i = 0; i < 3; i++) send(50, 4, 3, "R6");
        for (int i = 0; i < 4; i++) send(60, 4, 2, "R6");
        // R6 native sample drops a partial run
        send(70, 4, 2, "R6");
        send(80, 4, 0, "R6");
        for (int i = 0; i < 4; i++) send(90, 4, 2, "R6");

        // R9 reset mid-run discards the partial sum
        send(4095, 1, 2, "R9");
        send(4095, 1, 2, "R9");
        do_reset();
        for (int i = 0; i < 4; i++) send(8, 1, 2, "R9");

        // random bursts with a held channel and mode, gaps and early aborts
        for (int b = 0; b < 60; b++) begin
            int mode;
            int ch;
            int len;
            int p;
            p = $urandom_range(0, 99);
            if (p < 15)      mode = 0;
            else if (p < 30) mode = 1;
            else if (p < 60) mode = 2;
            else if (p < 80) mode = 3;
            else if (p < 92) mode = 4;
            else if (p < 97) mode = 5;
            else             mode = $urandom_range(6, 7);
            ch  = $urandom_range(0, 15);
            len = $urandom_range(1, 2 * (1 << (2 * ext_bits(mode))) + 3);
            for (int i = 0; i < len; i++) begin
                send($urandom_range(0, 4095), ch, mode, mode_tag(mode));
                if ($urandom_range(0, 9) == 0) idle($urandom_range(1, 3));
            end
        end
        idle(2);
        report();
    end

endmodule